// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two IEEE-754 operands, both single precision or both double precision, and turns the outcome into a four-bit condition code (negative, zero, carry, overflow) that downstream branch logic can consume. A precision select picks the format. Single operands sit in the low 32 bits of each operand port. A compare-with-zero select replaces the second operand by +0.0. A signalling-compare select changes how NaNs raise the invalid-operation status.

When flush-to-zero is enabled, subnormal inputs are treated as zeros of the same sign before ordering, and the fact is recorded. Two sticky status bits, invalid-operation and input-denormal, collect events across compares until an explicit clear. The flags register on the clock edge at which the valid strobe is high and hold otherwise.

Top module: `fp_cmp_flags`

## Requirements
- R1: After a synchronous active-low reset, all four flags and both sticky bits read 0.
- R2: On the edge where `valid_i` is high the flags load {N,Z,C,V} = 0110 for equal, 1000 when operand A is less than operand B, and 0010 when A is greater. When `valid_i` is low the flags keep their value and no sticky bit is set.
- R3: If either compared operand is a NaN (exponent all ones, fraction non-zero), the flags load 0011.
- R4: In quiet mode (`sig_cmp_i`=0) the invalid sticky bit is set only when a compared operand is a signalling NaN. A NaN is signalling when its fraction MSB is 0: bit 22 for singles, bit 51 for doubles.
- R5: In signalling mode (`sig_cmp_i`=1) every unordered compare sets the invalid sticky bit.
- R6: With `ftz_i`=1, each subnormal compared operand (exponent zero, fraction non-zero) orders as a zero of its own sign and sets the denormal sticky bit. With `ftz_i`=0, subnormals order by value and the denormal bit is not set.
- R7: With `zero_cmp_i`=1, operand B is ignored and +0.0 takes its place, under the same flag and NaN rules.
- R8: +0 and -0 compare as equal.
- R9: Sticky bits OR in new events and hold until `clr_i`. On a clear edge the bits drop to 0, except that an event on a valid compare in that same cycle is kept.
- R10: With `dbl_i`=0 only bits 31:0 of each operand are used. Bits 63:32 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Compare strobe |
| dbl_i | input | 1 | 1 = double precision, 0 = single |
| sig_cmp_i | input | 1 | 1 = signalling compare, 0 = quiet |
| zero_cmp_i | input | 1 | 1 = compare operand A with +0.0 |
| ftz_i | input | 1 | Flush subnormal inputs to zero |
| clr_i | input | 1 | Clear both sticky bits |
| op_a_i | input | 64 | Operand A |
| op_b_i | input | 64 | Operand B |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow (unordered) flag |
| sticky_inv_o | output | 1 | Sticky invalid-operation status |
| sticky_den_o | output | 1 | Sticky input-denormal status |

## Verification
The sticky clear and a new status event can land on the same edge. The clear would wipe the bits while the compare raises them again. The bench provokes this by asserting `clr_i` together with a valid compare of a signalling NaN under flush-to-zero with a subnormal operand. It then expects both sticky bits to read 1 afterwards, and expects a following clear with no event to read 0. The behavioural model computes the same OR-after-clear rule every cycle, so random traffic that mixes clears and NaN or subnormal operands is judged on each edge as well.

// File: rtl/fpcmp_pkg.sv
// Package: shared formats, operand summary record and flag encoding for the
// floating-point compare flag unit. Assumes IEEE-754 binary32/binary64.
package fpcmp_pkg;

    localparam int OPW   = 64;          // operand port width
    localparam int DEXPW = 11;          // double exponent width
    localparam int DMANW = 52;          // double fraction width
    localparam int SEXPW = 8;           // single exponent width
    localparam int SMANW = 23;          // single fraction width
    localparam int MAGW  = DEXPW + DMANW; // widest magnitude (no sign)

    // Summary of one operand after classification and optional flushing.
    typedef struct packed {
        logic            sign;
        logic [MAGW-1:0] mag;    // exponent:fraction, zeroed when flushed
        logic            nan;
        logic            snan;
        logic            zero;   // true zero or flushed subnormal
        logic            sub;    // raw subnormal, before flushing
    } opnd_t;

    typedef enum logic [1:0] {
        ORD_EQ = 2'd0,
        ORD_LT = 2'd1,
        ORD_GT = 2'd2,
        ORD_UN = 2'd3
    } order_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // Map an ordering outcome onto the condition-code encoding.
    function automatic nzcv_t flags_of(order_e ord);
        nzcv_t f;
        case (ord)
            ORD_EQ:  f = '{n: 1'b0, z: 1'b1, c: 1'b1, v: 1'b0};
            ORD_LT:  f = '{n: 1'b1, z: 1'b0, c: 1'b0, v: 1'b0};
            ORD_GT:  f = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b0};
            default: f = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b1};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/fpcmp_unpack.sv
// Module: fpcmp_unpack
// Splits one IEEE-754 value of a parameterised format into sign, magnitude
// and class bits, and optionally flushes a subnormal to a signed zero.
// Assumes EXP_W + MAN_W <= fpcmp_pkg::MAGW. Purely combinational.
module fpcmp_unpack
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = DEXPW,
    parameter int MAN_W = DMANW
) (
    input  logic [EXP_W+MAN_W:0] raw_i,
    input  logic                 ftz_i,
    output opnd_t                cls_o
);

    localparam int BODY_W = EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_ones;
    logic             exp_none;
    logic             man_any;
    logic             is_sub;
    logic             do_flush;
    logic [MAGW-1:0]  mag_ext;

    assign exp_f    = raw_i[BODY_W-1:MAN_W];
    assign man_f    = raw_i[MAN_W-1:0];
    assign exp_ones = &exp_f;
    assign exp_none = ~|exp_f;
    assign man_any  = |man_f;
    assign is_sub   = exp_none & man_any;
    assign do_flush = ftz_i & is_sub;

    // Zero-extend exponent:fraction into the common magnitude width.
    always_comb begin
        mag_ext               = '0;
        mag_ext[BODY_W-1:0]   = raw_i[BODY_W-1:0];
    end

    // Assemble the operand summary; a flushed subnormal keeps its sign.
    always_comb begin
        cls_o.sign = raw_i[BODY_W];
        cls_o.mag  = do_flush ? '0 : mag_ext;
        cls_o.nan  = exp_ones & man_any;
        cls_o.snan = exp_ones & man_any & ~man_f[MAN_W-1];
        cls_o.zero = exp_none & (~man_any | do_flush);
        cls_o.sub  = is_sub;
    end

endmodule

// File: rtl/fpcmp_order.sv
// Module: fpcmp_order
// Orders two classified operands of the same format: equal, less, greater
// or unordered. Zeros of either sign are equal. Purely combinational.
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  opnd_t  a_i,
    input  opnd_t  b_i,
    output order_e ord_o
);

    logic mag_lt;
    logic mag_eq;

    assign mag_lt = a_i.mag < b_i.mag;
    assign mag_eq = a_i.mag == b_i.mag;

    // Sign-magnitude ordering with NaN and signed-zero handling.
    always_comb begin
        if (a_i.nan || b_i.nan) begin
            ord_o = ORD_UN;
        end else if (a_i.zero && b_i.zero) begin
            ord_o = ORD_EQ;
        end else if (a_i.sign != b_i.sign) begin
            ord_o = a_i.sign ? ORD_LT : ORD_GT;
        end else if (mag_eq) begin
            ord_o = ORD_EQ;
        end else if (mag_lt) begin
            ord_o = a_i.sign ? ORD_GT : ORD_LT;
        end else begin
            ord_o = a_i.sign ? ORD_LT : ORD_GT;
        end
    end

endmodule

// File: rtl/fpcmp_status.sv
// Module: fpcmp_status
// Holds the condition flags and the two sticky status bits. Flags load on a
// valid compare; sticky bits clear on clr_i but keep a same-cycle event.
// Assumes a synchronous active-low reset.
module fpcmp_status
    import fpcmp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   valid_i,
    input  logic   clr_i,
    input  logic   sig_cmp_i,
    input  logic   ftz_i,
    input  order_e ord_i,
    input  logic   any_snan_i,
    input  logic   any_sub_i,
    output nzcv_t  flags_o,
    output logic   inv_o,
    output logic   den_o
);

    nzcv_t flags_q;
    logic  inv_q;
    logic  den_q;
    logic  inv_evt;
    logic  den_evt;

    // Status events raised by the current compare.
    always_comb begin
        inv_evt = valid_i & (sig_cmp_i ? (ord_i == ORD_UN) : any_snan_i);
        den_evt = valid_i & ftz_i & any_sub_i;
    end

    // Flag register: load on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (valid_i) begin
            flags_q <= flags_of(ord_i);
        end
    end

    // Sticky bits: clear first, then OR in this cycle's events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q <= 1'b0;
            den_q <= 1'b0;
        end else begin
            inv_q <= (inv_q & ~clr_i) | inv_evt;
            den_q <= (den_q & ~clr_i) | den_evt;
        end
    end

    assign flags_o = flags_q;
    assign inv_o   = inv_q;
    assign den_o   = den_q;

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(flags_q)); // R2

    AST_INV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        inv_q && !clr_i |=> inv_q); // R9

    AST_DEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        den_q && !clr_i |=> den_q); // R9

    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !valid_i |=> !inv_q && !den_q); // R9

endmodule

// File: rtl/fp_cmp_flags.sv
// Module: fp_cmp_flags (top)
// Compares two single or double operands and registers NZCV flags plus
// sticky invalid and input-denormal bits. Singles use bits 31:0 of each
// operand port. Both formats are decoded in parallel; dbl_i selects one.
module fp_cmp_flags
    import fpcmp_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           valid_i,
    input  logic           dbl_i,
    input  logic           sig_cmp_i,
    input  logic           zero_cmp_i,
    input  logic           ftz_i,
    input  logic           clr_i,
    input  logic [OPW-1:0] op_a_i,
    input  logic [OPW-1:0] op_b_i,
    output logic           flag_n_o,
    output logic           flag_z_o,
    output logic           flag_c_o,
    output logic           flag_v_o,
    output logic           sticky_inv_o,
    output logic           sticky_den_o
);

    localparam int NOPS = 2;
    localparam int SW   = SEXPW + SMANW + 1;
    localparam int DW   = DEXPW + DMANW + 1;

    logic [OPW-1:0] raw [NOPS];
    opnd_t          cls [NOPS];
    order_e         ord;
    nzcv_t          flags;

    // Operand B becomes +0.0 in compare-with-zero mode.
    always_comb begin
        raw[0] = op_a_i;
        raw[1] = zero_cmp_i ? '0 : op_b_i;
    end

    for (genvar i = 0; i < NOPS; i++) begin : g_opnd
        opnd_t cls_s;
        opnd_t cls_d;

        fpcmp_unpack #(.EXP_W(SEXPW), .MAN_W(SMANW)) u_sgl (
            .raw_i (raw[i][SW-1:0]),
            .ftz_i (ftz_i),
            .cls_o (cls_s)
        );

        fpcmp_unpack #(.EXP_W(DEXPW), .MAN_W(DMANW)) u_dbl (
            .raw_i (raw[i][DW-1:0]),
            .ftz_i (ftz_i),
            .cls_o (cls_d)
        );

        // Precision select for this operand.
        assign cls[i] = dbl_i ? cls_d : cls_s;
    end

    fpcmp_order u_order (
        .a_i   (cls[0]),
        .b_i   (cls[1]),
        .ord_o (ord)
    );

    fpcmp_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (valid_i),
        .clr_i      (clr_i),
        .sig_cmp_i  (sig_cmp_i),
        .ftz_i      (ftz_i),
        .ord_i      (ord),
        .any_snan_i (cls[0].snan | cls[1].snan),
        .any_sub_i  (cls[0].sub | cls[1].sub),
        .flags_o    (flags),
        .inv_o      (sticky_inv_o),
        .den_o      (sticky_den_o)
    );

    assign flag_n_o = flags.n;
    assign flag_z_o = flags.z;
    assign flag_c_o = flags.c;
    assign flag_v_o = flags.v;

    AST_NAN_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && (cls[0].nan || cls[1].nan)
        |=> flag_v_o && flag_c_o && !flag_z_o && !flag_n_o); // R3

    AST_QUIET_INV: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && !sig_cmp_i && !cls[0].snan && !cls[1].snan && !sticky_inv_o
        |=> !sticky_inv_o); // R4

    AST_SIG_INV: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && sig_cmp_i && (cls[0].nan || cls[1].nan)
        |=> sticky_inv_o); // R5

    AST_FTZ_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && ftz_i && cls[0].sub |=> sticky_den_o); // R6

    AST_ZERO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && cls[0].zero && cls[1].zero |=> flag_z_o && !flag_v_o); // R8

endmodule

// File: tb/tb_fp_cmp_flags.sv
`timescale 1ns/1ps
module tb_fp_cmp_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0, dbl_i = 1'b0, sig_cmp_i = 1'b0;
    logic        zero_cmp_i = 1'b0, ftz_i = 1'b0, clr_i = 1'b0;
    logic [63:0] op_a_i = '0, op_b_i = '0;
    logic        flag_n_o, flag_z_o, flag_c_o, flag_v_o;
    logic        sticky_inv_o, sticky_den_o;

    int checks = 0;
    int errors = 0;

    // model state
    logic [3:0] m_flags = 4'b0000;
    logic       m_inv = 1'b0, m_den = 1'b0;

    always #2.5 clk = ~clk;

    fp_cmp_flags dut (.*);

    function automatic void classify(input logic [63:0] x, input logic dp,
                                     input logic fz, output real v,
                                     output bit nan, output bit snan,
                                     output bit sub);
        int e;
        longint unsigned m;
        bit s;
        if (dp) begin
            e = int'(x[62:52]); m = longint'(x[51:0]); s = x[63];
            nan  = (e == 2047) && (m != 0);
            snan = nan && !x[51];
            sub  = (e == 0) && (m != 0);
            v    = $bitstoreal(x);
        end else begin
            e = int'(x[30:23]); m = longint'(x[22:0]); s = x[31];
            nan  = (e == 255) && (m != 0);
            snan = nan && !x[22];
            sub  = (e == 0) && (m != 0);
            if (e == 255) v = $bitstoreal(64'h7FF0000000000000);
            else if (e == 0) v = real'(m) * (2.0 ** (-149));
            else v = (real'(m) + 8388608.0) * (2.0 ** (e - 150));
            if (s) v = -v;
        end
        if (fz && sub) v = 0.0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        logic [3:0] f;
        f = {flag_n_o, flag_z_o, flag_c_o, flag_v_o};
        check(f === m_flags, req, "flags", f, m_flags);
        check(sticky_inv_o === m_inv, req, "inv", {3'b0, sticky_inv_o}, {3'b0, m_inv});
        check(sticky_den_o === m_den, req, "den", {3'b0, sticky_den_o}, {3'b0, m_den});
    endtask

    // One clock: drive, update the model at the edge, compare mid-cycle.
    task automatic step(input logic v, dp, sg, zm, fz, cl,
                        input logic [63:0] a, b, input string req);
        real va, vb;
        bit na, sa, ua, nb, sb, ub, inv_e, den_e, un;
        valid_i = v; dbl_i = dp; sig_cmp_i = sg; zero_cmp_i = zm;
        ftz_i = fz; clr_i = cl; op_a_i = a; op_b_i = b;
        @(posedge clk);
        classify(a, dp, fz, va, na, sa, ua);
        if (zm) begin vb = 0.0; nb = 0; sb = 0; ub = 0; end
        else classify(b, dp, fz, vb, nb, sb, ub);
        un    = na || nb;
        inv_e = v && (sg ? un : (sa || sb));
        den_e = v && fz && (ua || ub);
        if (!rst_n) begin
            m_flags = 4'b0000; m_inv = 0; m_den = 0;
        end else begin
            m_inv = (m_inv && !cl) || inv_e;
            m_den = (m_den && !cl) || den_e;
            if (v) begin
                if (un)           m_flags = 4'b0011;
                else if (va == vb) m_flags = 4'b0110;
                else if (va < vb)  m_flags = 4'b1000;
                else               m_flags = 4'b0010;
            end
        end
        @(negedge clk);
        compare_all(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        step(1, 0, 0, 0, 0, 0, 64'h0, 64'h0, "R1");
        step(1, 0, 0, 0, 0, 0, 64'h0, 64'h0, "R1");
        rst_n = 1'b1;
        // R1: reset state
        check({flag_n_o, flag_z_o, flag_c_o, flag_v_o} === 4'b0000, "R1", "reset flags",
              {flag_n_o, flag_z_o, flag_c_o, flag_v_o}, 4'b0000);
        check({sticky_inv_o, sticky_den_o} === 2'b00, "R1", "reset sticky",
              {2'b0, sticky_inv_o, sticky_den_o}, 4'b0000);

        // R2: ordering, singles and doubles
        step(1, 0, 0, 0, 0, 0, 64'h3F800000, 64'h40000000, "R2");
        step(1, 0, 0, 0, 0, 0, 64'h40000000, 64'h3F800000, "R2");
        step(1, 0, 0, 0, 0, 0, 64'h3F800000, 64'h3F800000, "R2");
        step(1, 0, 0, 0, 0, 0, 64'hBF800000, 64'hC0000000, "R2");
        step(1, 0, 0, 0, 0, 0, 64'hBF800000, 64'h3F800000, "R2");
        step(1, 1, 0, 0, 0, 0, 64'h3FF0000000000000, 64'h4000000000000000, "R2");
        step(1, 1, 0, 0, 0, 0, 64'hC000000000000000, 64'hBFF0000000000000, "R2");
        // R2: hold with valid low, NaN on inputs raises nothing
        step(0, 0, 1, 0, 1, 0, 64'h7F800001, 64'h00000001, "R2");
        step(0, 1, 1, 0, 1, 0, 64'h7FF0000000000001, 64'h1, "R2");

        // R3 and R4: quiet NaN in quiet mode, flags unordered, no invalid
        step(1, 0, 0, 0, 0, 0, 64'h7FC00000, 64'h3F800000, "R3");
        step(1, 1, 0, 0, 0, 0, 64'h0, 64'h7FF8000000000000, "R4");
        // R4: signalling NaN sets invalid (single then double)
        step(1, 0, 0, 0, 0, 0, 64'h7F800001, 64'h3F800000, "R4");
        step(1, 0, 0, 0, 0, 1, 64'h0, 64'h0, "R9");
        step(1, 1, 0, 0, 0, 0, 64'h3FF0000000000000, 64'hFFF0000000000001, "R4");
        step(1, 0, 0, 0, 0, 1, 64'h0, 64'h0, "R9");
        // R5: signalling mode, quiet NaN sets invalid
        step(1, 0, 1, 0, 0, 0, 64'h3F800000, 64'hFFC00000, "R5");
        step(1, 0, 1, 0, 0, 0, 64'h3F800000, 64'h3F800000, "R5");
        step(0, 0, 0, 0, 0, 1, 64'h0, 64'h0, "R9");

        // R6: flush on and off
        step(1, 0, 0, 0, 1, 0, 64'h00000001, 64'h00000000, "R6");
        step(1, 0, 0, 0, 1, 0, 64'h80000001, 64'h00000001, "R6");
        step(0, 0, 0, 0, 0, 1, 64'h0, 64'h0, "R9");
        step(1, 0, 0, 0, 0, 0, 64'h00000001, 64'h00000000, "R6");
        step(1, 0, 0, 0, 0, 0, 64'h80000002, 64'h80000001, "R6");
        step(1, 1, 0, 0, 1, 0, 64'h0000000000000005, 64'h8000000000000000, "R6");
        step(1, 1, 0, 0, 0, 0, 64'h0000000000000005, 64'h8000000000000000, "R6");

        // R7: compare with zero, B ignored
        step(1, 0, 0, 1, 0, 0, 64'hBF800000, 64'h7FC00000, "R7");
        step(1, 0, 0, 1, 0, 0, 64'h80000000, 64'hBF800000, "R7");
        step(1, 1, 1, 1, 0, 0, 64'h4000000000000000, 64'hFFF8000000000000, "R7");
        step(1, 1, 1, 1, 0, 0, 64'h7FF8000000000000, 64'h0, "R7");

        // R8: signed zeros
        step(1, 0, 0, 0, 0, 0, 64'h80000000, 64'h00000000, "R8");
        step(1, 1, 0, 0, 0, 0, 64'h0, 64'h8000000000000000, "R8");

        // R9: clear and event on the same edge, then plain clear
        step(1, 0, 0, 0, 1, 0, 64'h00000001, 64'h0, "R9");
        step(1, 0, 0, 0, 1, 1, 64'h7F800001, 64'h00000003, "R9");
        check(sticky_inv_o && sticky_den_o, "R9", "clear+event keeps",
              {2'b0, sticky_inv_o, sticky_den_o}, 4'b0011);
        step(0, 0, 0, 0, 0, 1, 64'h0, 64'h0, "R9");
        check(!sticky_inv_o && !sticky_den_o, "R9", "clear drops",
              {2'b0, sticky_inv_o, sticky_den_o}, 4'b0000);

        // R10: upper bits ignored in single mode
        step(1, 0, 0, 0, 0, 0, {32'hFFFFFFFF, 32'h3F800000}, {32'h12345678, 32'h3F800000}, "R10");
        step(1, 0, 0, 0, 0, 0, {32'h7FF00000, 32'h40000000}, {32'h0, 32'h3F800000}, "R10");

        // random traffic
        for (int i = 0; i < 600; i++) begin
            logic [63:0] a, b;
            logic dp;
            int k;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            dp = 1'($urandom);
            k = $urandom % 8;
            case (k)
                0: if (dp) a[62:52] = '1; else a[30:23] = '1;
                1: if (dp) b[62:52] = '0; else b[30:23] = '0;
                2: b = a;
                3: begin b = a; if (dp) b[63] = ~b[63]; else b[31] = ~b[31]; end
                4: if (dp) a[62:0] = '0; else a[30:0] = '0;
                default: ;
            endcase
            step(1'($urandom % 4 != 0), dp, 1'($urandom), 1'($urandom % 5 == 0),
                 1'($urandom), 1'($urandom % 6 == 0), a, b, "R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule